// File: doc/BRIEF.md
# Enumeration Center Multiply-Accumulator

This block computes the projected center of a new child level in a depth-first lattice enumeration. The center is the negated dot product of the already fixed coordinates `x_j` with one column of Gram–Schmidt coefficients `mu_j,i`. A job starts with a handshake that carries a term count and a preload value. The block then takes one `(mu, x)` operand pair per cycle on a valid/ready stream and feeds it through a pipelined signed multiplier into a 48-bit accumulator. When the pipeline has drained, it presents one result on a second valid/ready stream.

The result carries four fields: the center in fixed point, with 12 integer bits and 24 fractional bits; the nearest integer to the center, rounded half up; a direction bit that gives the first zig-zag step; and an overflow flag. The preload lets a caller pass in a partial sum for trailing terms whose coordinates have not changed, so that only the changed terms stream through the multiplier. The parameter `PRELOAD_RAW` fixes the sign convention at synthesis. With 1, the default, the preload is an un-negated partial dot product. With 0, the preload is already a partial center.

Back-pressure works as follows. The operand stream stalls freely: a pair is consumed only on a cycle where `op_valid` and `op_ready` are both high. A finished result stays on the result port, unchanged, until `res_ready` is seen high. While a result is waiting, the block accepts no new job.

Top module: `enum_center_mac`

## Requirements
- R1: `start_ready` is high exactly when no job is in progress and no result is pending. A job is taken on a cycle where `start` and `start_ready` are both high, and that cycle captures `term_count` and `preload`. A `start` at any other time has no effect.
- R2: After a job is taken, `op_ready` is high until exactly `term_count` operand pairs have been accepted, and low otherwise. Cycles with `op_valid` low consume nothing.
- R3: Each accepted pair contributes `mu * x` to a 48-bit signed accumulator. `mu` is a signed 24-bit value with 24 fractional bits, sign-extended to 25 bits. `x` is a signed 18-bit integer. The accumulator starts from the preload, which is a 48-bit signed value with 24 fractional bits.
- R4: With the default `PRELOAD_RAW=1`, `res_center` equals the low 36 bits of `-(preload + sum of products)`, in two's complement with 24 fractional bits.
- R5: A job with `term_count` zero yields `-preload` as its center.
- R6: `res_valid` rises on the third rising edge after the edge that accepted the last operand pair. For a zero-count job it rises on the first edge after the start handshake.
- R7: `res_coord` is the delivered center rounded half up: `floor(center + 1/2)`, a 13-bit integer sign-extended to 18 bits.
- R8: `res_dir_up` is 1 exactly when the delivered center is strictly less than `res_coord`. Otherwise it is 0, which means the first step is downward.
- R9: `res_ovf` is 1 exactly when the true value of `-(preload + sum)` lies outside the signed 36-bit range [-2^35, 2^35-1].
- R10: While `res_valid` is high and `res_ready` is low, all result fields hold steady. After the result handshake, `res_valid` drops and `start_ready` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a job |
| start_ready | output | 1 | Block is idle and can take a job |
| term_count | input | 7 | Number of operand pairs in the job |
| preload | input | 48 | Initial accumulator value, 24 fractional bits |
| op_valid | input | 1 | Operand pair present |
| op_ready | output | 1 | Block consumes an operand pair this cycle |
| op_mu | input | 24 | Signed coefficient, 24 fractional bits |
| op_x | input | 18 | Signed integer coordinate |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result |
| res_center | output | 36 | Center, signed, 12 integer and 24 fractional bits |
| res_coord | output | 18 | Center rounded half up, signed integer |
| res_dir_up | output | 1 | 1 when center < rounded coordinate |
| res_ovf | output | 1 | Center does not fit in 36 bits |

## Verification
The hardest cases to reach from the ports are centers that sit exactly on a rounding boundary or exactly on the edge of the 36-bit range. Random operand pairs almost never land there. The stimulus reaches them through zero-count jobs, where the preload alone sets the center to any chosen fixed-point value, such as ±1/2, an exact integer, or ±2^35 and its neighbours. A second hard case is a start request that arrives while a result is held back by `res_ready`. The bench produces it by raising `start` during a long back-pressure window and checking that neither the result nor the job state changes.

// File: rtl/ecm_pkg.sv
package ecm_pkg;

  // Controller state for one center computation
  typedef enum logic [1:0] {
    ECM_IDLE = 2'd0,
    ECM_RUN  = 2'd1,
    ECM_DONE = 2'd2
  } ecm_state_e;

endpackage

// File: rtl/ecm_mul_pipe.sv
// Two register stages of the product path: operand capture, then product.
// The accumulator that follows forms the third stage.
module ecm_mul_pipe #(
  parameter int MU_W  = 24,
  parameter int X_W   = 18,
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [MU_W-1:0]  mu,
  input  logic [X_W-1:0]   x,
  output logic             s1_valid,
  output logic             prod_valid,
  output logic [ACC_W-1:0] prod
);

  localparam int MUX_W = MU_W + 1;
  localparam int P_W   = MUX_W + X_W;
  localparam int EXT_W = ACC_W - P_W;

  logic signed [MUX_W-1:0] mu_r;
  logic signed [X_W-1:0]   x_r;
  logic signed [P_W-1:0]   p_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      prod_valid <= 1'b0;
    end else begin
      s1_valid   <= in_valid;
      prod_valid <= s1_valid;
    end
  end

  // coefficient widened by one sign bit before the multiply
  always_ff @(posedge clk) begin
    if (in_valid) begin
      mu_r <= {mu[MU_W-1], mu};
      x_r  <= x;
    end
  end

  assign p_w = mu_r * x_r;

  always_ff @(posedge clk) begin
    if (s1_valid) begin
      prod <= {{EXT_W{p_w[P_W-1]}}, p_w};
    end
  end

endmodule

// File: rtl/ecm_accum.sv
module ecm_accum #(
  parameter int ACC_W       = 48,
  parameter bit PRELOAD_RAW = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACC_W-1:0] preload,
  input  logic             add_valid,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc
);

  logic [ACC_W-1:0] init_val;

  // The stored sum is always un-negated; a preload that is already a
  // center is flipped on entry.
  generate
    if (PRELOAD_RAW) begin : g_raw
      assign init_val = preload;
    end else begin : g_neg
      assign init_val = {ACC_W{1'b0}} - preload;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (load) begin
      acc <= init_val;
    end else if (add_valid) begin
      acc <= acc + addend;
    end
  end

endmodule

// File: rtl/ecm_round.sv
// Negation, range test, round-half-up and direction, all combinational.
module ecm_round #(
  parameter int ACC_W  = 48,
  parameter int FRAC_W = 24,
  parameter int INT_W  = 12,
  parameter int X_W    = 18
) (
  input  logic [ACC_W-1:0]        acc,
  output logic [FRAC_W+INT_W-1:0] center,
  output logic [X_W-1:0]          coord,
  output logic                    dir_up,
  output logic                    ovf
);

  localparam int C_W = FRAC_W + INT_W;
  localparam int N_W = ACC_W + 1;
  localparam int R_W = C_W + 1;
  localparam int K_W = INT_W + 1;
  localparam int H_W = N_W - C_W + 1;

  logic [N_W-1:0] neg;
  logic [H_W-1:0] head;
  logic [R_W-1:0] cext;
  logic [K_W-1:0] kint;

  assign neg    = {N_W{1'b0}} - {acc[ACC_W-1], acc};
  assign head   = neg[N_W-1:C_W-1];
  assign ovf    = !((&head) || !(|head));
  assign center = neg[C_W-1:0];
  assign cext   = {center[C_W-1], center};

  // floor of the center plus the half bit gives the nearest integer
  assign kint   = cext[R_W-1:FRAC_W] + K_W'(cext[FRAC_W-1]);
  assign coord  = {{(X_W-K_W){kint[K_W-1]}}, kint};
  assign dir_up = $signed({kint, {FRAC_W{1'b0}}}) > $signed(cext);

endmodule

// File: rtl/ecm_ctrl.sv
module ecm_ctrl
  import ecm_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  output logic             start_ready,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             pipe_busy,
  output logic             load,
  output logic             accept,
  output logic             capture,
  output logic             res_valid,
  input  logic             res_ready
);

  ecm_state_e       state;
  logic [CNT_W-1:0] left;

  assign start_ready = (state == ECM_IDLE);
  assign op_ready    = (state == ECM_RUN) && (left != '0);
  assign accept      = op_valid && op_ready;
  assign load        = start && start_ready;
  assign capture     = (state == ECM_RUN) && (left == '0) && !pipe_busy;
  assign res_valid   = (state == ECM_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ECM_IDLE;
      left  <= '0;
    end else begin
      unique case (state)
        ECM_IDLE: begin
          if (load) begin
            state <= ECM_RUN;
            left  <= count;
          end
        end
        ECM_RUN: begin
          if (accept) left <= left - 1'b1;
          if (capture) state <= ECM_DONE;
        end
        ECM_DONE: begin
          if (res_ready) state <= ECM_IDLE;
        end
        default: state <= ECM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/enum_center_mac.sv
module enum_center_mac #(
  parameter int MU_W        = 24,
  parameter int X_W         = 18,
  parameter int ACC_W       = 48,
  parameter int INT_W       = 12,
  parameter int CNT_W       = 7,
  parameter bit PRELOAD_RAW = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  output logic                   start_ready,
  input  logic [CNT_W-1:0]       term_count,
  input  logic [ACC_W-1:0]       preload,
  input  logic                   op_valid,
  output logic                   op_ready,
  input  logic [MU_W-1:0]        op_mu,
  input  logic [X_W-1:0]         op_x,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic [MU_W+INT_W-1:0]  res_center,
  output logic [X_W-1:0]         res_coord,
  output logic                   res_dir_up,
  output logic                   res_ovf
);

  localparam int FRAC_W = MU_W;
  localparam int C_W    = FRAC_W + INT_W;

  logic             load, accept, capture;
  logic             s1_valid, prod_valid;
  logic [ACC_W-1:0] prod, acc;
  logic [C_W-1:0]   nx_center;
  logic [X_W-1:0]   nx_coord;
  logic             nx_dir, nx_ovf;

  ecm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .count      (term_count),
    .start_ready(start_ready),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .pipe_busy  (s1_valid | prod_valid),
    .load       (load),
    .accept     (accept),
    .capture    (capture),
    .res_valid  (res_valid),
    .res_ready  (res_ready)
  );

  ecm_mul_pipe #(.MU_W(MU_W), .X_W(X_W), .ACC_W(ACC_W)) u_mul (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (accept),
    .mu        (op_mu),
    .x         (op_x),
    .s1_valid  (s1_valid),
    .prod_valid(prod_valid),
    .prod      (prod)
  );

  ecm_accum #(.ACC_W(ACC_W), .PRELOAD_RAW(PRELOAD_RAW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .preload  (preload),
    .add_valid(prod_valid),
    .addend   (prod),
    .acc      (acc)
  );

  ecm_round #(.ACC_W(ACC_W), .FRAC_W(FRAC_W), .INT_W(INT_W), .X_W(X_W)) u_rnd (
    .acc   (acc),
    .center(nx_center),
    .coord (nx_coord),
    .dir_up(nx_dir),
    .ovf   (nx_ovf)
  );

  // result register, loaded once the pipeline is empty
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_center <= '0;
      res_coord  <= '0;
      res_dir_up <= 1'b0;
      res_ovf    <= 1'b0;
    end else if (capture) begin
      res_center <= nx_center;
      res_coord  <= nx_coord;
      res_dir_up <= nx_dir;
      res_ovf    <= nx_ovf;
    end
  end

endmodule

// File: rtl/ecm_chk.sv
module ecm_chk #(
  parameter int FRAC_W = 24,
  parameter int INT_W  = 12,
  parameter int X_W    = 18,
  parameter int CNT_W  = 7
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    start_ready,
  input logic [CNT_W-1:0]        term_count,
  input logic                    op_valid,
  input logic                    op_ready,
  input logic                    res_valid,
  input logic                    res_ready,
  input logic [FRAC_W+INT_W-1:0] res_center,
  input logic [X_W-1:0]          res_coord,
  input logic                    res_dir_up,
  input logic                    res_ovf
);

  localparam int C_W = FRAC_W + INT_W;
  localparam int D_W = X_W + FRAC_W + 2;

  logic [CNT_W-1:0]      owed;
  logic signed [D_W-1:0] diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed <= '0;
    else if (start && start_ready) owed <= term_count;
    else if (op_valid && op_ready) owed <= owed - 1'b1;
  end

  assign diff = D_W'($signed(res_center)) - ($signed(D_W'($signed(res_coord))) <<< FRAC_W);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    start_ready |-> (!res_valid && !op_ready));

  a_r2_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (owed != '0));

  a_r6_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready) |=> !res_valid);

  a_r7_nearest: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ovf) |->
      (diff >= -(D_W'(1) <<< (FRAC_W-1))) && (diff < (D_W'(1) <<< (FRAC_W-1))));

  a_r8_dir_half: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_dir_up == res_center[FRAC_W-1]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_center) && $stable(res_coord)
                                   && $stable(res_dir_up) && $stable(res_ovf)));

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && start_ready));

endmodule

bind enum_center_mac ecm_chk #(
  .FRAC_W(MU_W),
  .INT_W (INT_W),
  .X_W   (X_W),
  .CNT_W (CNT_W)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_ready(start_ready),
  .term_count (term_count),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_center (res_center),
  .res_coord  (res_coord),
  .res_dir_up (res_dir_up),
  .res_ovf    (res_ovf)
);

// File: tb/test_enum_center_mac.sv
`timescale 1ns/1ps
module test_enum_center_mac;

  localparam int  FRAC = 24;
  localparam longint HALF = 64'sd1 <<< (FRAC-1);
  localparam longint ONE  = 64'sd1 <<< FRAC;
  localparam longint CMAX = (64'sd1 <<< 35) - 1;
  localparam longint CMIN = -(64'sd1 <<< 35);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        start_ready;
  logic [6:0]  term_count = '0;
  logic [47:0] preload = '0;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [23:0] op_mu = '0;
  logic [17:0] op_x = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [35:0] res_center;
  logic [17:0] res_coord;
  logic        res_dir_up;
  logic        res_ovf;

  always #2.5 clk = ~clk;

  enum_center_mac i_enum_center_mac (.*);

  int n_checks = 0;
  int n_err = 0;
  bit finished = 1'b0;
  int unsigned seed = 32'h1234_5678;
  string tag = "R1";

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned lcg();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  // ---------------- behavioural reference model ----------------
  bit     m_busy = 0, m_run = 0, m_valid = 0;
  int     m_rem = 0, m_cd = 0;
  longint m_acc = 0;
  longint e_center = 0, e_coord = 0;
  bit     e_dir = 0, e_ovf = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_run = 0; m_valid = 0; m_rem = 0; m_cd = 0; m_acc = 0;
    end else begin
      bit st, acc_op;
      st     = start && !m_busy;
      acc_op = op_valid && m_run && (m_rem > 0);
      if (m_valid && res_ready) begin m_valid = 0; m_busy = 0; end
      if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          longint c, c36;
          logic [63:0] cb;
          m_valid = 1; m_run = 0;
          c = -m_acc;
          cb = c;
          e_ovf = (c > CMAX) || (c < CMIN);
          c36 = longint'($signed(cb[35:0]));
          e_center = c36;
          e_coord = (c36 + HALF) >>> FRAC;
          e_dir = c36 < (e_coord * ONE);
        end
      end
      if (acc_op) begin
        m_acc += longint'($signed(op_mu)) * longint'($signed(op_x));
        m_rem--;
        if (m_rem == 0) m_cd = 3;
      end
      if (st) begin
        m_busy = 1; m_run = 1; m_rem = term_count;
        m_acc = longint'($signed(preload));
        if (term_count == 0) m_cd = 1;
      end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(start_ready == !m_busy, "R1", "start_ready", start_ready, !m_busy);
      check(op_ready == (m_run && m_rem > 0), "R2", "op_ready", op_ready, m_run && m_rem > 0);
      check(res_valid == m_valid, {"R6/", tag}, "res_valid", res_valid, m_valid);
      if (m_valid && res_valid) begin
        check(longint'($signed(res_center)) == e_center, {"R4/", tag}, "center",
              longint'($signed(res_center)), e_center);
        check(longint'($signed(res_coord)) == e_coord, {"R7/", tag}, "coord",
              longint'($signed(res_coord)), e_coord);
        check(res_dir_up == e_dir, {"R8/", tag}, "dir_up", res_dir_up, e_dir);
        check(res_ovf == e_ovf, {"R9/", tag}, "ovf", res_ovf, e_ovf);
      end
    end
  end

  // ---------------- stimulus ----------------
  longint mu_q[$];
  longint x_q[$];

  task automatic run_job(longint pre, int gap_every, int hold, bit poke_start);
    int n;
    n = mu_q.size();
    while (!start_ready) @(negedge clk);
    res_ready = (hold == 0);
    start = 1; term_count = 7'(n); preload = 48'(pre);
    @(negedge clk);
    start = 0;
    for (int k = 0; k < n; k++) begin
      bit took;
      if (gap_every > 0 && (k % gap_every) == 1) begin
        op_valid = 0;
        @(negedge clk);
      end
      op_valid = 1; op_mu = 24'(mu_q[k]); op_x = 18'(x_q[k]);
      took = 0;
      while (!took) begin
        took = op_ready;
        @(negedge clk);
      end
    end
    op_valid = 0;
    while (!res_valid) @(negedge clk);
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        // R1: a start while the result is pending must change nothing
        start = poke_start; term_count = 7'd3; preload = 48'h1;
        @(negedge clk);
      end
      start = 0;
      res_ready = 1;
    end
    @(negedge clk);
    mu_q.delete(); x_q.delete();
  endtask

  task automatic rand_terms(int n);
    for (int k = 0; k < n; k++) begin
      mu_q.push_back(longint'($signed(24'(lcg()))));
      x_q.push_back(longint'($signed(18'(lcg()))));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(start_ready == 1 && res_valid == 0 && op_ready == 0, "R1", "reset idle",
          {start_ready, res_valid, op_ready}, 3'b100);
    rst_n = 1;
    @(negedge clk);

    // R5: zero term count returns the negated preload
    tag = "R5"; run_job(5 * ONE + 123, 0, 0, 0);
    // R7/R8: center +1/2 rounds up, direction up
    tag = "R7"; run_job(-HALF, 0, 0, 0);
    // R7/R8: center -1/2 rounds to 0, direction up
    tag = "R8"; run_job(HALF, 0, 0, 0);
    // R8: exact integer center, direction down
    tag = "R8"; run_job(-3 * ONE, 0, 0, 0);
    // R3/R4: single product 0.25 * 3 gives -0.75
    tag = "R3"; mu_q.push_back(64'sd1 <<< 22); x_q.push_back(3); run_job(0, 0, 0, 0);
    // R2/R6: stalls on the operand stream
    tag = "R2"; rand_terms(7); run_job(longint'($signed(20'(lcg()))) * 256, 2, 0, 0);
    // R10/R1: back-pressure with a start request during the hold
    tag = "R10"; rand_terms(5); run_job(-7 * ONE, 0, 6, 1);
    // R4/R6: long job without gaps
    tag = "R4"; rand_terms(64); run_job(0, 0, 0, 0);
    // R9: range boundaries
    tag = "R9"; run_job(-(64'sd1 <<< 35), 0, 0, 0);
    tag = "R9"; run_job(64'sd1 <<< 35, 0, 0, 0);
    tag = "R9"; run_job((64'sd1 <<< 35) + 1, 0, 0, 0);
    tag = "R9"; run_job(-(64'sd1 <<< 35) + 1, 0, 0, 0);
    // R9: extreme products accumulate far past the range
    tag = "R9";
    for (int k = 0; k < 40; k++) begin
      mu_q.push_back(-(64'sd1 <<< 23)); x_q.push_back(-(64'sd1 <<< 17));
    end
    run_job(0, 3, 2, 0);
    // R4: random preloads and products
    for (int j = 0; j < 6; j++) begin
      tag = "R4"; rand_terms(1 + j * 3); run_job(longint'($signed(30'(lcg()))), j % 3, j % 2, 1);
    end

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule